// File: doc/BRIEF.md
# Packed Dual-Byte Arithmetic Unit

This combinational unit splits each 16-bit operand into two independent byte lanes, the low lane in bits 7:0 and the high lane in bits 15:8, and applies one arithmetic operation to both lane pairs at once. The two 8-bit lane results are packed back into one 16-bit word, high lane in the upper byte. A 4-bit operation select chooses between lane-wise add, subtract, multiply and divide.

Two flags accompany the result. Each one is the OR of the same condition evaluated in both lanes. The unit holds no state and has no clock, so the result and flags follow the operands and the select directly. It suits a datapath that needs short-vector byte arithmetic without widening its word.

There are no states or transitions to name. The only branching is the choice of operation made from the select value.

Top module: `packed_byte_alu`

## Requirements
- R1: The select encodes the operation as follows: 4'b1000 multiply, 4'b1001 divide, 4'b1010 add and 4'b1011 subtract. The result is {op(opa[15:8], opb[15:8]), op(opa[7:0], opb[7:0])}.
- R2: For add, each lane result is the lane sum modulo 256, and no carry passes from bit 7 into bit 8.
- R3: For subtract, each lane result is the lane difference modulo 256, and no borrow passes from bit 8 down into the low lane or from the low lane up.
- R4: `uovf` is high only for add, and only when at least one lane produces a carry out of its bit 7. It is low for every other select value.
- R5: For add, `sovf` is high when, in either lane, both operands have the same sign bit and the lane result has the other sign bit.
- R6: For subtract, `sovf` is high when, in either lane, the operands have different sign bits and the lane result's sign bit differs from that of the minuend (opa). `uovf` stays low.
- R7: Multiply treats lanes as unsigned and returns the low 8 bits of each 16-bit lane product. Both flags are low.
- R8: Divide treats lanes as unsigned and returns the truncated quotient in each lane. Both flags are low.
- R9: A lane whose divisor is zero returns 8'hFF, and the other lane's quotient is unaffected.
- R10: Any select value outside 4'b1000 to 4'b1011 gives a zero result with both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 16 | First operand: two packed bytes (minuend, dividend) |
| opb | input | 16 | Second operand: two packed bytes (subtrahend, divisor) |
| sel | input | 4 | Operation select |
| result | output | 16 | Packed lane results |
| uovf | output | 1 | Unsigned overflow: OR of the lane carries, add only |
| sovf | output | 1 | Signed overflow: OR of the lane flags, add and subtract |

## Verification
Every output is due in the same cycle as the stimulus because no register lies between any input and any output. The only latency is the settling of the adder, multiplier and eight-stage divider chains. The bench changes the inputs just after a rising edge of its pacing clock. It reads `result`, `uovf` and `sovf` at the following falling edge, half a period later, when the logic has settled. No check ever depends on an earlier vector.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        OP_MUL = 4'b1000,
        OP_DIV = 4'b1001,
        OP_ADD = 4'b1010,
        OP_SUB = 4'b1011
    } lane_op_e;

endpackage

// File: rtl/byte_lane_addsub.sv
module byte_lane_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         sov
);

    logic [W-1:0] b_eff;

    always_comb begin
        b_eff       = do_sub ? ~b : b;
        {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
        sov         = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

    always_comb begin
        if (!do_sub && cout) begin
            AST_CARRY_WRAPS: assert (sum < a) else $error("carry without wrap"); // R4
        end
        if (!do_sub && sov) begin
            AST_ADD_SOV_SIGNS: assert (a[W-1] == b[W-1]) else $error("add sov sign"); // R5
        end
        if (do_sub && sov) begin
            AST_SUB_SOV_SIGNS: assert (a[W-1] != b[W-1]) else $error("sub sov sign"); // R6
        end
    end

endmodule

// File: rtl/byte_lane_mul.sv
module byte_lane_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p
);

    localparam int W2 = 2 * W;

    always_comb begin
        p = a * b;
    end

    always_comb begin
        if (b == W'(1)) begin
            AST_MUL_IDENTITY: assert (p == a) else $error("mul by one"); // R7
        end
        if (a == '0 || b == '0) begin
            AST_MUL_ZERO: assert (p == '0) else $error("mul by zero"); // R7
        end
        AST_MUL_LOW_BITS: assert (W2'(p) == (W2'(a) * W2'(b)) % (W2'(1) << W))
            else $error("mul low bits"); // R7
    end

endmodule

// File: rtl/byte_lane_div.sv
module byte_lane_div #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] q,
    output logic [W-1:0] r
);

    localparam int W2 = 2 * W;

    logic [W-1:0] rem [0:W];

    assign rem[0] = '0;

    for (genvar k = 0; k < W; k++) begin : g_stage
        logic [W:0]   shifted;
        logic [W-1:0] trial;
        logic         take;

        always_comb begin
            shifted       = {rem[k], a[W-1-k]};
            trial         = shifted[W-1:0] - b;
            take          = (shifted >= {1'b0, b});
            q[W-1-k]      = take;
        end

        assign rem[k+1] = take ? trial : shifted[W-1:0];
    end

    assign r = rem[W];

    always_comb begin
        if (b != '0) begin
            AST_DIV_IDENTITY: assert (W2'(q) * W2'(b) + W2'(r) == W2'(a))
                else $error("div identity"); // R8
            AST_DIV_REM_SMALL: assert (r < b) else $error("div remainder"); // R8
        end else begin
            AST_DIV_ZERO_ONES: assert (q == '1) else $error("div by zero"); // R9
        end
    end

endmodule

// File: rtl/packed_byte_alu.sv
module packed_byte_alu
    import psimd_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic [SEL_W-1:0]  sel,
    output logic [WORD_W-1:0] result,
    output logic              uovf,
    output logic              sovf
);

    logic [WORD_W-1:0] sum_w;
    logic [WORD_W-1:0] prod_w;
    logic [WORD_W-1:0] quot_w;
    logic [WORD_W-1:0] rem_w;
    logic [LANES-1:0]  carry_w;
    logic [LANES-1:0]  sov_w;
    logic              is_sub;

    assign is_sub = (sel == OP_SUB);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        byte_lane_addsub #(.W(LANE_W)) u_addsub (
            .a      (opa[g*LANE_W +: LANE_W]),
            .b      (opb[g*LANE_W +: LANE_W]),
            .do_sub (is_sub),
            .sum    (sum_w[g*LANE_W +: LANE_W]),
            .cout   (carry_w[g]),
            .sov    (sov_w[g])
        );

        byte_lane_mul #(.W(LANE_W)) u_mul (
            .a (opa[g*LANE_W +: LANE_W]),
            .b (opb[g*LANE_W +: LANE_W]),
            .p (prod_w[g*LANE_W +: LANE_W])
        );

        byte_lane_div #(.W(LANE_W)) u_div (
            .a (opa[g*LANE_W +: LANE_W]),
            .b (opb[g*LANE_W +: LANE_W]),
            .q (quot_w[g*LANE_W +: LANE_W]),
            .r (rem_w[g*LANE_W +: LANE_W])
        );

        always_comb begin
            AST_REM_BOUND: assert ((opb[g*LANE_W +: LANE_W] == '0) ||
                                   (rem_w[g*LANE_W +: LANE_W] < opb[g*LANE_W +: LANE_W]))
                else $error("lane remainder"); // R8
        end
    end

    always_comb begin
        result = '0;
        uovf   = 1'b0;
        sovf   = 1'b0;
        unique case (sel)
            OP_ADD: begin
                result = sum_w;
                uovf   = |carry_w;
                sovf   = |sov_w;
            end
            OP_SUB: begin
                result = sum_w;
                sovf   = |sov_w;
            end
            OP_MUL: result = prod_w;
            OP_DIV: result = quot_w;
            default: ;
        endcase
    end

    always_comb begin
        if (uovf) begin
            AST_UOVF_ADD_ONLY: assert (sel == OP_ADD) else $error("uovf off add"); // R4
        end
        if (sovf) begin
            AST_SOVF_ARITH_ONLY: assert (sel == OP_ADD || sel == OP_SUB)
                else $error("sovf off add/sub"); // R5
        end
        if (sel[SEL_W-1:SEL_W-2] != 2'b10) begin
            AST_IDLE_QUIET: assert (result == '0 && !uovf && !sovf)
                else $error("idle select active"); // R10
        end
    end

endmodule

// File: tb/tb_packed_byte_alu.sv
module tb_packed_byte_alu;

    logic        clk = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic [3:0]  sel = '0;
    logic [15:0] result;
    logic        uovf;
    logic        sovf;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    packed_byte_alu dut (
        .opa    (opa),
        .opb    (opb),
        .sel    (sel),
        .result (result),
        .uovf   (uovf),
        .sovf   (sovf)
    );

    function automatic logic [17:0] model(logic [15:0] a, logic [15:0] b, logic [3:0] s);
        logic [15:0] res = '0;
        logic u = 1'b0;
        logic v = 1'b0;
        for (int i = 0; i < 2; i++) begin
            logic [7:0] x = a[8*i +: 8];
            logic [7:0] y = b[8*i +: 8];
            logic [8:0] w;
            logic [15:0] m;
            logic [7:0] r = '0;
            case (s)
                4'b1010: begin
                    w = {1'b0, x} + {1'b0, y};
                    r = w[7:0];
                    u = u | w[8];
                    v = v | ((x[7] == y[7]) && (r[7] != x[7]));
                end
                4'b1011: begin
                    r = x - y;
                    v = v | ((x[7] != y[7]) && (r[7] != x[7]));
                end
                4'b1000: begin
                    m = {8'h00, x} * {8'h00, y};
                    r = m[7:0];
                end
                4'b1001: r = (y == 8'h00) ? 8'hFF : x / y;
                default: r = 8'h00;
            endcase
            res[8*i +: 8] = r;
        end
        return {u, v, res};
    endfunction

    function automatic string tags(logic [3:0] s);
        case (s)
            4'b1010: return "R1 R2 R4 R5";
            4'b1011: return "R1 R3 R4 R6";
            4'b1000: return "R1 R4 R7";
            4'b1001: return "R1 R8 R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [17:0] exp);
        logic [17:0] got = {uovf, sovf, result};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: opa=%h opb=%h sel=%b got u=%b s=%b res=%h expected u=%b s=%b res=%h",
                     req, opa, opb, sel, got[17], got[16], got[15:0], exp[17], exp[16], exp[15:0]);
        end
    endtask

    task automatic apply(logic [15:0] a, logic [15:0] b, logic [3:0] s, string req, logic [17:0] exp);
        @(posedge clk);
        opa = a;
        opb = b;
        sel = s;
        @(negedge clk);
        check(req, exp);
    endtask

    initial begin
        // R10: idle state with zero inputs
        @(negedge clk);
        check("R10 initial", 18'h0);
        // R2 R4: low lane carry must not enter the high lane
        apply(16'h00FF, 16'h0001, 4'b1010, "R2 R4", {2'b10, 16'h0000});
        // R2 R4 R5: both lanes wrap, signed overflow in high lane
        apply(16'h80FF, 16'h8001, 4'b1010, "R2 R4 R5", {2'b11, 16'h0000});
        // R5: positive plus positive turns negative in low lane only
        apply(16'h0140, 16'h0140, 4'b1010, "R5", {2'b01, 16'h0280});
        // R3: low lane borrow must not reach the high lane
        apply(16'h0000, 16'h0001, 4'b1011, "R3 R4", {2'b00, 16'h00FF});
        // R6: negative minus positive becomes positive
        apply(16'h8000, 16'h0100, 4'b1011, "R6", {2'b01, 16'h7F00});
        // R6: equal-sign subtract never flags
        apply(16'hF005, 16'hF106, 4'b1011, "R6", {2'b00, 16'hFFFF});
        // R7: product truncation per lane, flags low
        apply(16'hFF02, 16'hFF80, 4'b1000, "R7", {2'b00, 16'h0100});
        // R8: truncated quotient
        apply(16'hC864, 16'h0307, 4'b1001, "R8", {2'b00, 16'h420E});
        // R9: zero divisor in low lane only
        apply(16'h1234, 16'h0300, 4'b1001, "R9", {2'b00, 16'h06FF});
        // R9: zero divisor in high lane only
        apply(16'h0050, 16'h0005, 4'b1001, "R9", {2'b00, 16'hFF10});
        // R10: unused selects
        apply(16'hFFFF, 16'hFFFF, 4'b0000, "R10", 18'h0);
        apply(16'h7F7F, 16'h0101, 4'b0111, "R10", 18'h0);
        apply(16'h8080, 16'h8080, 4'b1111, "R10", 18'h0);

        void'($urandom(32'd1357));
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a = 16'($urandom);
            logic [15:0] b = 16'($urandom);
            logic [3:0]  s = (n % 4 == 0) ? 4'($urandom) : 4'(4'b1000 + ($urandom % 4));
            if (n % 11 == 0) b[7:0] = 8'h00;
            if (n % 13 == 0) b[15:8] = 8'h00;
            if (n % 17 == 0) a = {8'h80, 8'h7F};
            apply(a, b, s, tags(s), model(a, b, s));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule